// File: doc/BRIEF.md
# I2C Read-Only Target with Hardware Clock Hold

This block is the target side of an I2C bus for transfers in which the bus controller reads data. It watches the SCL and SDA lines through synchronizers and detects Start and Stop conditions. It then receives an address frame. The frame is 7 address bits sent MSB first, followed by a direction bit in which 1 means read. When the address equals the programmed value and the direction bit is 1, the block acknowledges. It then holds SCL low until the local host has supplied a byte and released the clock.

Each data byte leaves MSB first. The controller's acknowledge is captured on the rising edge of the ninth clock. A per-byte interrupt flag is raised on the falling edge of that ninth clock. An acknowledge makes the block hold SCL again for the next byte. A not-acknowledge ends the transfer.

When collision checking is enabled, the block compares the line with the value it drives. If it releases SDA to send a 1 but reads a 0, it flags a collision and withdraws from the bus. Both lines are open drain: each output port is an active-high pull-low enable.

Top module: `i2c_read_target`

## Requirements
- R1: A frame whose upper 7 bits equal `own_addr` and whose last bit is 1 (read) sets `rd_mode`, copies the whole 8-bit frame to `rx_buf`, and pulls SDA low during the ninth clock.
- R2: From the falling edge of the ninth clock of an acknowledged read address, `scl_oe` holds SCL low until a `clk_release` pulse, so the controller cannot raise SCL.
- R3: Data bits go out MSB first. The first bit appears on SDA while SCL is still held. Every later bit is updated only after a falling SCL edge, so SDA is stable while SCL is high.
- R4: `ack_stat` takes the SDA level seen at the rising edge of the ninth clock of a data byte (0 = acknowledge, 1 = not-acknowledge). It changes at no other time.
- R5: After a not-acknowledge the block does not hold SCL, goes idle and answers nothing until the next Start. The interrupt flag is still raised.
- R6: After an acknowledge, SCL is held low again from the falling edge of the ninth clock until the next `clk_release`. A byte written with `tx_wr` while SCL is held is the next one sent.
- R7: `irq` rises on the falling edge of the ninth clock of the address frame and of every data byte. It stays high until `irq_clr`.
- R8: With `coll_en` = 1, a data bit sent as 1 (SDA released) that reads 0 at the rising SCL edge sets `coll` and returns the block to idle with SDA released. `irq_clr` clears `coll`.
- R9: A Stop (SDA rising while SCL is high) aborts any transfer and releases both lines. A Start (SDA falling while SCL is high) restarts address reception from any state.
- R10: `buf_full` is set when an address frame is loaded into `rx_buf` and cleared by `buf_rd`.
- R11: A Stop, or an address frame that is not acknowledged, clears `rd_mode`. A frame with a different address, or with direction bit 0, is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | ADDR_W | Address this target answers |
| coll_en | input | 1 | Enable SDA collision checking |
| tx_wr | input | 1 | Load `tx_data` into the output shift register |
| tx_data | input | DATA_W | Byte to transmit |
| clk_release | input | 1 | Pulse: stop holding SCL |
| irq_clr | input | 1 | Pulse: clear `irq` and `coll` |
| buf_rd | input | 1 | Pulse: host read `rx_buf`, clears `buf_full` |
| rx_buf | output | ADDR_W+1 | Last acknowledged address frame |
| buf_full | output | 1 | `rx_buf` holds an unread frame |
| irq | output | 1 | Per-byte interrupt flag |
| rd_mode | output | 1 | Addressed for reading |
| ack_stat | output | 1 | Controller acknowledge of the last byte (1 = not-acknowledge) |
| coll | output | 1 | Collision seen while sending |

## Verification
The assertions check on every cycle that the interrupt flag only rises right after a detected falling SCL edge. They check that `ack_stat` changes only right after a rising SCL edge, and that SDA drive changes only while SCL is low. They also check that the clock hold only starts on a falling edge, that a not-acknowledge leads to idle, and that a collision leaves the block idle. Only the bench scenarios can show the rest. That covers the actual bit order on the wire and the controller being unable to raise SCL while it is held. It also covers a Stop in mid-byte ending the transfer, and write-direction or foreign addresses going unanswered.

// File: rtl/i2c_rt_pkg.sv
`timescale 1ns/1ps
package i2c_rt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_HOLD,
    ST_SHIFT,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_rt_sync.sv
`timescale 1ns/1ps
module i2c_rt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] chain_q [W];

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= '1;
      else        chain_q[g] <= {chain_q[g][STAGES-2:0], d[g]};
    end
    assign q[g] = chain_q[g][STAGES-1];
  end
endmodule

// File: rtl/i2c_rt_events.sv
`timescale 1ns/1ps
module i2c_rt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_rt_shifter.sv
`timescale 1ns/1ps
module i2c_rt_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb,
  output logic         nxt
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];
  assign nxt = sr_q[W-2];
endmodule

// File: rtl/i2c_read_target.sv
`timescale 1ns/1ps
module i2c_read_target
  import i2c_rt_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              coll_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              clk_release,
  input  logic              irq_clr,
  input  logic              buf_rd,
  output logic [ADDR_W:0]   rx_buf,
  output logic              buf_full,
  output logic              irq,
  output logic              rd_mode,
  output logic              ack_stat,
  output logic              coll
);
  localparam int FRAME_W  = ADDR_W + 1;
  localparam int MAX_BITS = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_rt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (arst_n), .d ({scl_i, sda_i}), .q ({scl_s, sda_s})
  );

  i2c_rt_events u_evt (
    .clk (clk), .rst_n (arst_n), .scl_s (scl_s), .sda_s (sda_s),
    .scl_rise (scl_rise), .scl_fall (scl_fall),
    .start_det (start_det), .stop_det (stop_det)
  );

  logic sr_load, sr_shift, sr_msb, sr_nxt;

  i2c_rt_shifter #(.W(DATA_W)) u_sr (
    .clk (clk), .rst_n (arst_n), .load (sr_load), .load_val (tx_data),
    .shift (sr_shift), .msb (sr_msb), .nxt (sr_nxt)
  );

  tgt_state_e         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] asr_q, asr_d, buf_q, buf_d;
  logic sda_oe_q, sda_oe_d, scl_oe_q, scl_oe_d;
  logic irq_q, irq_d, ack_q, ack_d, rd_q, rd_d, bf_q, bf_d, coll_q, coll_d;
  logic hit;

  assign hit = (asr_q[FRAME_W-1:1] == own_addr) && asr_q[0];

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    asr_d    = asr_q;
    buf_d    = buf_q;
    sda_oe_d = sda_oe_q;
    scl_oe_d = scl_oe_q;
    irq_d    = irq_q;
    ack_d    = ack_q;
    rd_d     = rd_q;
    bf_d     = bf_q;
    coll_d   = coll_q;
    sr_load  = tx_wr && (st_q != ST_SHIFT);
    sr_shift = 1'b0;
    if (irq_clr) begin
      irq_d  = 1'b0;
      coll_d = 1'b0;
    end
    if (buf_rd) bf_d = 1'b0;
    if (stop_det) begin
      st_d     = ST_IDLE;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
      rd_d     = 1'b0;
    end else if (start_det) begin
      st_d     = ST_ADDR;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            asr_d = {asr_q[FRAME_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(FRAME_W)) begin
            if (hit) begin
              st_d     = ST_AACK;
              sda_oe_d = 1'b1;
              rd_d     = 1'b1;
              bf_d     = 1'b1;
              buf_d    = asr_q;
            end else begin
              st_d = ST_IDLE;
              rd_d = 1'b0;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            st_d     = ST_HOLD;
            sda_oe_d = ~sr_msb;
            scl_oe_d = 1'b1;
            irq_d    = 1'b1;
          end
        end
        ST_HOLD: begin
          if (tx_wr) sda_oe_d = ~tx_data[DATA_W-1];
          if (clk_release) begin
            st_d     = ST_SHIFT;
            scl_oe_d = 1'b0;
            cnt_d    = '0;
          end
        end
        ST_SHIFT: begin
          if (scl_rise) begin
            if (coll_en && !sda_oe_q && !sda_s) begin
              coll_d = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(DATA_W)) begin
              st_d     = ST_MACK;
              sda_oe_d = 1'b0;
            end else begin
              sr_shift = 1'b1;
              sda_oe_d = ~sr_nxt;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ack_d = sda_s;
          end else if (scl_fall) begin
            irq_d = 1'b1;
            if (ack_q) begin
              st_d = ST_IDLE;
            end else begin
              st_d     = ST_HOLD;
              scl_oe_d = 1'b1;
              sda_oe_d = ~sr_msb;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      asr_q    <= '0;
      buf_q    <= '0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
      irq_q    <= 1'b0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      bf_q     <= 1'b0;
      coll_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      asr_q    <= asr_d;
      buf_q    <= buf_d;
      sda_oe_q <= sda_oe_d;
      scl_oe_q <= scl_oe_d;
      irq_q    <= irq_d;
      ack_q    <= ack_d;
      rd_q     <= rd_d;
      bf_q     <= bf_d;
      coll_q   <= coll_d;
    end
  end

  assign scl_oe   = scl_oe_q;
  assign sda_oe   = sda_oe_q;
  assign rx_buf   = buf_q;
  assign buf_full = bf_q;
  assign irq      = irq_q;
  assign rd_mode  = rd_q;
  assign ack_stat = ack_q;
  assign coll     = coll_q;

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq_q) |-> $past(scl_fall)); // R7
  AST_ACK_ON_RISE: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(ack_q) |-> $past(scl_rise)); // R4
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(sda_oe_q) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R3
  AST_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(scl_oe_q) |-> $past(scl_fall)); // R2
  AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    $past(st_q == ST_MACK && scl_fall && ack_q && !start_det && !stop_det)
    |-> (st_q == ST_IDLE && !scl_oe_q)); // R5
  AST_COLL_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(coll_q) |-> (st_q == ST_IDLE && !sda_oe_q)); // R8
  AST_BUF_WITH_READ: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(bf_q) |-> rd_q); // R10
endmodule

// File: tb/tb_i2c_read_target.sv
`timescale 1ns/1ps
module tb_i2c_read_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, sda_force = 1'b0;
  logic scl_oe, sda_oe;
  logic [6:0] own_addr = 7'h5A;
  logic coll_en = 1'b0, tx_wr = 1'b0, clk_release = 1'b0, irq_clr = 1'b0, buf_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_buf;
  logic buf_full, irq, rd_mode, ack_stat, coll;
  logic scl_ln, sda_ln;

  assign scl_ln = scl_m & ~scl_oe;
  assign sda_ln = sda_m & ~sda_oe & ~sda_force;

  i2c_read_target dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_ln), .sda_i (sda_ln),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .own_addr (own_addr), .coll_en (coll_en),
    .tx_wr (tx_wr), .tx_data (tx_data), .clk_release (clk_release),
    .irq_clr (irq_clr), .buf_rd (buf_rd), .rx_buf (rx_buf), .buf_full (buf_full),
    .irq (irq), .rd_mode (rd_mode), .ack_stat (ack_stat), .coll (coll)
  );

  // behavioural model of the visible state
  int total = 0, bad = 0;
  bit cmp_en = 1'b0;
  logic m_irq = 0, m_ack = 0, m_rd = 0, m_bf = 0, m_hold = 0, m_coll = 0;
  logic [7:0] m_buf = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check(irq == m_irq, "R7 irq", irq, m_irq);
      check(ack_stat == m_ack, "R4 ack_stat", ack_stat, m_ack);
      check(rd_mode == m_rd, "R11 rd_mode", rd_mode, m_rd);
      check(buf_full == m_bf, "R10 buf_full", buf_full, m_bf);
      check(scl_oe == m_hold, "R2 scl_oe", scl_oe, m_hold);
      check(coll == m_coll, "R8 coll", coll, m_coll);
      check(rx_buf == m_buf, "R1 rx_buf", rx_buf, m_buf);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_step(input logic c, input logic d);
    cmp_en = 1'b0;
    scl_m = c;
    sda_m = d;
    while (scl_ln !== c) @(posedge clk);
    tick(5);
  endtask

  task automatic settle();
    cmp_en = 1'b1;
    tick(2);
  endtask

  task automatic do_irq_clr();
    cmp_en = 1'b0;
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(3);
    m_irq = 1'b0; m_coll = 1'b0;
    settle();
  endtask

  task automatic do_buf_rd();
    cmp_en = 1'b0;
    buf_rd = 1'b1; tick(1); buf_rd = 1'b0; tick(3);
    m_bf = 1'b0;
    settle();
  endtask

  task automatic do_load(input logic [7:0] v);
    tx_data = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; tick(3);
  endtask

  task automatic do_rel();
    cmp_en = 1'b0;
    clk_release = 1'b1; tick(1); clk_release = 1'b0; tick(5);
    m_hold = 1'b0;
    settle();
  endtask

  task automatic do_start();
    bus_step(1, 1); settle();
    bus_step(1, 0); settle();
    bus_step(0, 0); settle();
  endtask

  task automatic do_stop();
    bus_step(0, 0); settle();
    bus_step(1, 0); settle();
    bus_step(1, 1); m_rd = 1'b0; settle();
  endtask

  task automatic send_addr(input logic [7:0] a, input bit hit, input string tag);
    for (int i = 7; i >= 0; i--) begin
      bus_step(0, a[i]); settle();
      bus_step(1, a[i]); settle();
      bus_step(0, a[i]);
      if (i == 0) begin
        if (hit) begin m_rd = 1'b1; m_bf = 1'b1; m_buf = a; end
        else m_rd = 1'b0;
      end
      settle();
    end
    bus_step(0, 1); settle();
    bus_step(1, 1);
    check(sda_ln == !hit, tag, sda_ln, !hit);
    settle();
    bus_step(0, 1);
    if (hit) begin m_irq = 1'b1; m_hold = 1'b1; end
    settle();
  endtask

  task automatic read_byte(input logic [7:0] e, input bit ack, input bit risen);
    if (!risen) begin bus_step(0, 1); settle(); end
    for (int i = 7; i >= 0; i--) begin
      if (!(i == 7 && risen)) begin bus_step(1, 1); settle(); end
      check(sda_ln == e[i], "R3 data bit", sda_ln, e[i]);
      bus_step(0, 1); settle();
    end
    bus_step(0, !ack); settle();
    bus_step(1, !ack); m_ack = !ack; settle();
    bus_step(0, !ack); m_irq = 1'b1; m_hold = ack; settle();
  endtask

  task automatic hold_probe(input string tag);
    scl_m = 1'b1;
    tick(20);
    check(scl_ln == 1'b0, tag, scl_ln, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(6);
    check(irq == 0, "R7 reset irq", irq, 0);
    check(scl_oe == 0 && sda_oe == 0, "R2 reset lines free", {scl_oe, sda_oe}, 0);
    check(buf_full == 0, "R10 reset buf_full", buf_full, 0);
    check(rd_mode == 0, "R1 reset rd_mode", rd_mode, 0);
    settle();

    // read of two bytes: ACK then NACK
    do_start();
    send_addr(8'hB5, 1, "R1 address ack");
    check(irq == 1, "R7 irq after address", irq, 1);
    hold_probe("R2 clock held after address");
    do_irq_clr();
    check(irq == 0, "R7 irq cleared", irq, 0);
    do_buf_rd();
    check(buf_full == 0, "R10 buf_full cleared", buf_full, 0);
    do_load(8'hA5);
    do_rel();
    check(scl_ln == 1, "R2 clock freed by release", scl_ln, 1);
    read_byte(8'hA5, 1, 1);
    check(ack_stat == 0, "R4 ack seen", ack_stat, 0);
    hold_probe("R6 clock held after ack");
    do_irq_clr();
    do_load(8'h3C);
    do_rel();
    read_byte(8'h3C, 0, 1);
    check(ack_stat == 1, "R4 nack seen", ack_stat, 1);
    check(irq == 1 && scl_oe == 0, "R5 nack end", {irq, scl_oe}, 2);
    bus_step(1, 1);
    check(scl_ln == 1, "R5 no hold after nack", scl_ln, 1);
    settle();
    // restart to another address
    bus_step(1, 0); settle();
    bus_step(0, 0); settle();
    send_addr(8'h23, 0, "R11 foreign address no ack");
    check(rd_mode == 0, "R11 rd_mode cleared", rd_mode, 0);
    do_stop();

    // collision while sending a 1
    do_irq_clr();
    do_start();
    send_addr(8'hB5, 1, "R1 address ack");
    coll_en = 1'b1;
    do_load(8'h80);
    do_rel();
    sda_force = 1'b1;
    bus_step(1, 1); m_coll = 1'b1; settle();
    check(coll == 1 && sda_oe == 0, "R8 collision flagged", {coll, sda_oe}, 2);
    bus_step(0, 1); settle();
    sda_force = 1'b0;
    bus_step(1, 1); settle();
    check(sda_oe == 0, "R8 idle after collision", sda_oe, 0);
    do_stop();
    do_irq_clr();
    check(coll == 0, "R8 coll cleared", coll, 0);
    coll_en = 1'b0;

    // Stop in the middle of a byte
    do_start();
    send_addr(8'hB5, 1, "R1 address ack");
    do_load(8'hFF);
    do_rel();
    bus_step(0, 1); settle();
    bus_step(1, 1);
    check(sda_ln == 1, "R3 first bit", sda_ln, 1);
    settle();
    bus_step(0, 1); settle();
    bus_step(1, 1); settle();
    do_stop();
    check(scl_oe == 0 && sda_oe == 0 && rd_mode == 0, "R9 stop aborts",
          {scl_oe, sda_oe, rd_mode}, 0);
    do_start();
    send_addr(8'hB5, 1, "R9 new start answered");
    do_buf_rd();
    do_load(8'hC3);
    do_rel();
    read_byte(8'hC3, 0, 0);
    do_stop();

    // write direction is not answered
    do_start();
    send_addr(8'hB4, 0, "R11 write frame no ack");
    check(buf_full == 0, "R10 no load on write frame", buf_full, 0);
    do_stop();

    cmp_en = 1'b0;
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule